// File: doc/BRIEF.md
# Three-Level Priority Arbiter with Bypass Limits

This block grants one access per cycle to a set of request ports. Each port presents a valid bit and a 2-bit source type: CPU read, isochronous write, ordinary (non-isochronous) write, or other. A small set of policy bits maps each source type to one of three priority levels, low, medium or high. The block then grants the highest level that has a request waiting. Within one level, the lowest-numbered port wins. The grant is combinational: the ready bit of the chosen port and the grant outputs change in the same cycle as the requests.

Strict priority alone would starve the lower levels, so two small bypass counters bound it. The high counter counts high grants made while medium or low work is waiting. The medium counter counts medium grants made while low work is waiting. When a counter has reached its programmed limit, its level steps aside for exactly one grant. That grant goes to the highest remaining level that has work. Serving the lower level, or the lower level running empty, restarts the count. The request queues and any data movement sit outside the block.

Top module: `prio_bypass_arb`

## Requirements
- R1: Source type code 1 (CPU read) maps to high priority when cfg_i bit 0 is 1 and to medium when it is 0.
- R2: Source type code 2 (ordinary write) maps to low priority when cfg_i bit 1 is 0 and to medium when it is 1.
- R3: Source type code 3 (isochronous write) maps to high when cfg_i bit 2 is 0, to medium when bit 2 is 1 and bit 3 is 0, and to low when bits 2 and 3 are both 1. Bit 3 alone has no effect.
- R4: Source type code 0 (other) always maps to medium priority.
- R5: Each grant goes to the highest non-suspended level with a valid request, and within that level to the lowest port index. req_rdy_o is one-hot on that port. gnt_lvl_o encodes low=0, medium=1, high=2. All of these follow the inputs in the same cycle.
- R6: The high bypass limit in cfg_i[7:6] allows that many consecutive high grants while medium or low work waits. The next contested grant then goes to a lower level. A limit of 0 makes high yield whenever lower work waits.
- R7: The medium bypass limit in cfg_i[5:4] allows that many medium grants while low work waits. The next grant where low could be served then goes to low. A limit of 0 allows none.
- R8: A bypass count restarts at zero when any level below it is granted, or when no level below it has work waiting.
- R9: When both the high and medium levels are suspended in the same cycle, the grant goes to the low level.
- R10: When requests sit at only one level, that level is granted every cycle whatever the counters hold. With no valid request, gnt_vld_o and req_rdy_o are 0.
- R11: Reset clears both bypass counts, so the first contested grant after reset follows plain priority whenever the limit is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 8 | Policy bits [3:0], medium bypass limit [5:4], high bypass limit [7:6] |
| req_vld_i | input | NUM_PORTS (3) | Request valid per port |
| req_typ_i | input | 2*NUM_PORTS (6) | Source type per port, port p at bits [2p+1:2p] |
| req_rdy_o | output | NUM_PORTS (3) | One-hot grant to the chosen port |
| gnt_vld_o | output | 1 | A grant is made this cycle |
| gnt_port_o | output | 2 | Index of the granted port |
| gnt_lvl_o | output | 2 | Priority level of the grant |

## Verification
The bench holds high and medium requests, or medium and low requests, valid across several cycles. It checks that the yield lands on exactly the cycle after the programmed number of passes. A counter that is off by one would shift the yield by a cycle, and a suspension that failed to end would hand out two lower grants in a row. A further sequence drops the lower request for one cycle and then restores it. A design that did not clear the count on an empty lower level would yield too early. The limit-0 case, the double suspension that must fall through to low, and ties inside a level are exercised directly. Each of these exposes a wrong fall-through order or a wrong port tie-break.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;

   localparam int NUM_LVL = 3;

   typedef enum logic [1:0] {
      LVL_LOW  = 2'd0,
      LVL_MED  = 2'd1,
      LVL_HIGH = 2'd2
   } lvl_e;

   typedef enum logic [1:0] {
      TY_OTHER   = 2'd0,
      TY_CPU_RD  = 2'd1,
      TY_WR_PLAIN = 2'd2,
      TY_WR_ISO  = 2'd3
   } src_ty_e;

   // Policy bits; bit 0 is the lowest bit of the configuration word.
   typedef struct packed {
      logic iso_to_low;    // bit 3, only acts together with bit 2
      logic iso_not_high;  // bit 2
      logic plain_raise;   // bit 1
      logic cpu_rd_high;   // bit 0
   } map_cfg_t;

   function automatic lvl_e map_level(input src_ty_e ty, input map_cfg_t c);
      lvl_e l;
      unique case (ty)
         TY_CPU_RD:   l = c.cpu_rd_high ? LVL_HIGH : LVL_MED;
         TY_WR_PLAIN: l = c.plain_raise ? LVL_MED : LVL_LOW;
         TY_WR_ISO: begin
            if (!c.iso_not_high)   l = LVL_HIGH;
            else if (c.iso_to_low) l = LVL_LOW;
            else                   l = LVL_MED;
         end
         default:     l = LVL_MED;
      endcase
      return l;
   endfunction

endpackage

// File: rtl/prio_lvl_map.sv
module prio_lvl_map
   import prio_arb_pkg::*;
#(
   parameter int NUM_PORTS = 3
) (
   input  logic [NUM_PORTS-1:0]                req_vld_i,
   input  logic [2*NUM_PORTS-1:0]              req_typ_i,
   input  map_cfg_t                            map_cfg_i,
   output logic [NUM_LVL-1:0][NUM_PORTS-1:0]   lvl_mask_o
);

   lvl_e port_lvl [NUM_PORTS];

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign port_lvl[p] = map_level(src_ty_e'(req_typ_i[2*p +: 2]), map_cfg_i);
   end

   always_comb begin
      lvl_mask_o = '0;
      for (int l = 0; l < NUM_LVL; l++) begin
         for (int p = 0; p < NUM_PORTS; p++) begin
            lvl_mask_o[l][p] = req_vld_i[p] && (port_lvl[p] == lvl_e'(l));
         end
      end
   end

endmodule

// File: rtl/prio_port_pick.sv
module prio_port_pick #(
   parameter int NUM_PORTS = 3,
   localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic [NUM_PORTS-1:0] mask_i,
   output logic                 found_o,
   output logic [PORT_W-1:0]    idx_o
);

   assign found_o = |mask_i;

   always_comb begin
      idx_o = '0;
      for (int p = NUM_PORTS - 1; p >= 0; p--) begin
         if (mask_i[p]) idx_o = PORT_W'(p);
      end
   end

endmodule

// File: rtl/prio_bypass_ctr.sv
module prio_bypass_ctr #(
   parameter int CNT_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] lim_i,
   input  logic             upper_wait_i,
   input  logic             lower_wait_i,
   input  logic             upper_won_i,
   input  logic             lower_won_i,
   output logic             yield_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q, cnt_d;

   assign yield_o = upper_wait_i && lower_wait_i && (cnt_q >= lim_i);

   always_comb begin
      cnt_d = cnt_q;
      if (lower_won_i || !lower_wait_i)           cnt_d = '0;
      else if (upper_won_i && cnt_q != CNT_MAX)   cnt_d = cnt_q + 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
   end

   // R6 / R7: at the limit the upper level must not win while lower work waits
   a_r6_r7_no_pass_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upper_wait_i && lower_wait_i && cnt_q >= lim_i) |-> !upper_won_i);

   // R8: serving the lower level restarts the count
   a_r8_clear_on_lower: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lower_won_i |=> (cnt_q == '0));

   // R8: an empty lower level restarts the count
   a_r8_clear_on_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lower_wait_i |=> (cnt_q == '0));

endmodule

// File: rtl/prio_bypass_arb.sv
module prio_bypass_arb
   import prio_arb_pkg::*;
#(
   parameter int NUM_PORTS = 3,
   parameter int CNT_W     = 2,
   localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int CFG_W    = 4 + 2 * CNT_W
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [CFG_W-1:0]       cfg_i,
   input  logic [NUM_PORTS-1:0]   req_vld_i,
   input  logic [2*NUM_PORTS-1:0] req_typ_i,
   output logic [NUM_PORTS-1:0]   req_rdy_o,
   output logic                   gnt_vld_o,
   output logic [PORT_W-1:0]      gnt_port_o,
   output logic [1:0]             gnt_lvl_o
);

   if (NUM_PORTS < 1) begin : g_chk_ports
      $error("prio_bypass_arb: NUM_PORTS must be at least 1");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_chk_cnt
      $error("prio_bypass_arb: CNT_W must be within 1..8");
   end

   map_cfg_t         map_cfg;
   logic [CNT_W-1:0] med_lim, hi_lim;

   assign map_cfg = map_cfg_t'(cfg_i[3:0]);
   assign med_lim = cfg_i[4 +: CNT_W];
   assign hi_lim  = cfg_i[4 + CNT_W +: CNT_W];

   logic [NUM_LVL-1:0][NUM_PORTS-1:0] lvl_mask;
   logic [NUM_LVL-1:0]                lvl_found;
   logic [PORT_W-1:0]                 lvl_idx [NUM_LVL];

   prio_lvl_map #(.NUM_PORTS(NUM_PORTS)) u_map (
      .req_vld_i  (req_vld_i),
      .req_typ_i  (req_typ_i),
      .map_cfg_i  (map_cfg),
      .lvl_mask_o (lvl_mask)
   );

   for (genvar l = 0; l < NUM_LVL; l++) begin : g_pick
      prio_port_pick #(.NUM_PORTS(NUM_PORTS)) u_pick (
         .mask_i  (lvl_mask[l]),
         .found_o (lvl_found[l]),
         .idx_o   (lvl_idx[l])
      );
   end

   logic hv, mv, lv;
   assign hv = lvl_found[LVL_HIGH];
   assign mv = lvl_found[LVL_MED];
   assign lv = lvl_found[LVL_LOW];

   logic hi_yield, med_yield;
   lvl_e sel;
   logic any;

   always_comb begin
      any = hv | mv | lv;
      if (hv && !hi_yield)       sel = LVL_HIGH;
      else if (mv && !med_yield) sel = LVL_MED;
      else if (lv)               sel = LVL_LOW;
      else if (mv)               sel = LVL_MED;
      else if (hv)               sel = LVL_HIGH;
      else                       sel = LVL_LOW;
   end

   logic won_hi, won_med, won_low;
   assign won_hi  = any && (sel == LVL_HIGH);
   assign won_med = any && (sel == LVL_MED);
   assign won_low = any && (sel == LVL_LOW);

   prio_bypass_ctr #(.CNT_W(CNT_W)) u_ctr_hi (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .lim_i        (hi_lim),
      .upper_wait_i (hv),
      .lower_wait_i (mv | lv),
      .upper_won_i  (won_hi),
      .lower_won_i  (won_med | won_low),
      .yield_o      (hi_yield)
   );

   prio_bypass_ctr #(.CNT_W(CNT_W)) u_ctr_med (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .lim_i        (med_lim),
      .upper_wait_i (mv),
      .lower_wait_i (lv),
      .upper_won_i  (won_med),
      .lower_won_i  (won_low),
      .yield_o      (med_yield)
   );

   assign gnt_vld_o  = any;
   assign gnt_lvl_o  = any ? sel : LVL_LOW;
   assign gnt_port_o = any ? lvl_idx[sel] : '0;

   always_comb begin
      for (int p = 0; p < NUM_PORTS; p++) begin
         req_rdy_o[p] = any && (gnt_port_o == PORT_W'(p));
      end
   end

   // R5: at most one port is granted, and only a port that asked
   a_r5_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(req_rdy_o));
   a_r5_rdy_needs_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_rdy_o & ~req_vld_i) == '0);
   // R10: a grant exactly when something is valid
   a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(|req_vld_i) |-> !gnt_vld_o);
   a_r10_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|req_vld_i) |-> gnt_vld_o);
   // R9: a yielding high level hands its grant below high
   a_r9_yield_goes_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hi_yield |-> (gnt_lvl_o != 2'd2));

endmodule

// File: tb/prio_bypass_arb_tb.sv
module prio_bypass_arb_tb;

   localparam int NP = 3;
   localparam logic [1:0] OTH = 2'd0, CRD = 2'd1, WRN = 2'd2, WRI = 2'd3;
   localparam logic [1:0] LO = 2'd0, MD = 2'd1, HI = 2'd2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    cfg = 8'h00;
   logic [NP-1:0] vld = '0;
   logic [5:0]    typ = '0;
   logic [NP-1:0] rdy;
   logic          gvld;
   logic [1:0]    gport;
   logic [1:0]    glvl;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   prio_bypass_arb u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .cfg_i      (cfg),
      .req_vld_i  (vld),
      .req_typ_i  (typ),
      .req_rdy_o  (rdy),
      .gnt_vld_o  (gvld),
      .gnt_port_o (gport),
      .gnt_lvl_o  (glvl)
   );

   // {vld[2:0], typ[5:0] (port2..port0), cfg[7:0], exp_vld, exp_port[1:0], exp_lvl[1:0]}
   localparam logic [21:0] VEC [13] = '{
      {3'b001, 6'b000001, 8'hF0, 1'b1, 2'd0, 2'd1},  // R1 cpu read medium
      {3'b011, 6'b000110, 8'hF0, 1'b1, 2'd1, 2'd1},  // R1 R2 medium over low
      {3'b011, 6'b000110, 8'hF1, 1'b1, 2'd1, 2'd2},  // R1 cpu read high
      {3'b110, 6'b111000, 8'hF0, 1'b1, 2'd2, 2'd2},  // R3 iso high
      {3'b110, 6'b110100, 8'hF4, 1'b1, 2'd1, 2'd1},  // R3 iso medium, R5 tie low index
      {3'b011, 6'b000111, 8'hFC, 1'b1, 2'd1, 2'd1},  // R3 iso low
      {3'b011, 6'b000010, 8'hF2, 1'b1, 2'd0, 2'd1},  // R2 raised, R4 other, R5 tie
      {3'b000, 6'b000000, 8'hF0, 1'b0, 2'd0, 2'd0},  // R10 idle
      {3'b101, 6'b010011, 8'hF8, 1'b1, 2'd0, 2'd2},  // R3 bit 3 alone ignored
      {3'b100, 6'b100000, 8'hF0, 1'b1, 2'd2, 2'd0},  // R2 plain write low
      {3'b011, 6'b000110, 8'h00, 1'b1, 2'd0, 2'd0},  // R7 limit 0
      {3'b110, 6'b110100, 8'h00, 1'b1, 2'd1, 2'd1},  // R6 limit 0
      {3'b011, 6'b000010, 8'hF0, 1'b1, 2'd1, 2'd1}   // R4 other medium over low
   };

   task automatic expect_gnt(input logic ev, input logic [1:0] ep,
                             input logic [1:0] el, input string tag);
      logic [NP-1:0] er;
      #2;
      er = ev ? (NP'(1) << ep) : '0;
      n_chk++;
      if (gvld !== ev || rdy !== er || (ev && (gport !== ep || glvl !== el))) begin
         n_err++;
         $display("FAIL %s: vld=%0b port=%0d lvl=%0d rdy=%b, expected vld=%0b port=%0d lvl=%0d rdy=%b",
                  tag, gvld, gport, glvl, rdy, ev, ep, el, er);
      end
      @(negedge clk);
   endtask

   task automatic idle_cycle();
      vld = '0;
      @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      n_err++;
      n_chk++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      @(negedge clk);
      expect_gnt(1'b0, 2'd0, LO, "R11 R10 reset idle");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: first contested grant after reset follows priority
      cfg = 8'h70;
      vld = 3'b110; typ = {WRI, CRD, OTH};
      expect_gnt(1'b1, 2'd2, HI, "R11 first grant after reset");
      // count now 1 = limit; reset must clear it
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      expect_gnt(1'b1, 2'd2, HI, "R11 reset clears count");
      idle_cycle();

      for (int i = 0; i < 13; i++) begin
         vld = VEC[i][21:19];
         typ = VEC[i][18:13];
         cfg = VEC[i][12:5];
         expect_gnt(VEC[i][4], VEC[i][3:2], VEC[i][1:0],
                    $sformatf("table row %0d (R1 R2 R3 R4 R5 R6 R7 R10)", i));
         idle_cycle();
      end

      // R6: high limit 2
      cfg = 8'hB0;
      vld = 3'b110; typ = {WRI, CRD, OTH};
      expect_gnt(1'b1, 2'd2, HI, "R6 pass 1");
      expect_gnt(1'b1, 2'd2, HI, "R6 pass 2");
      expect_gnt(1'b1, 2'd1, MD, "R6 yield");
      expect_gnt(1'b1, 2'd2, HI, "R6 single yield only");
      idle_cycle();

      // R7: medium limit 1
      cfg = 8'hD0;
      vld = 3'b011; typ = {OTH, CRD, WRN};
      expect_gnt(1'b1, 2'd1, MD, "R7 pass 1");
      expect_gnt(1'b1, 2'd0, LO, "R7 yield to low");
      expect_gnt(1'b1, 2'd1, MD, "R7 medium again");
      expect_gnt(1'b1, 2'd0, LO, "R7 yield again");
      idle_cycle();

      // R10: a single level with limit 0 is always granted
      cfg = 8'h00;
      vld = 3'b100; typ = {WRI, OTH, OTH};
      for (int k = 0; k < 4; k++) expect_gnt(1'b1, 2'd2, HI, "R10 lone high");
      idle_cycle();

      // R9: high limit 1, medium limit 0, all three levels waiting
      cfg = 8'h40;
      vld = 3'b111; typ = {WRI, CRD, WRN};
      expect_gnt(1'b1, 2'd2, HI, "R9 high first");
      expect_gnt(1'b1, 2'd0, LO, "R9 both suspended -> low");
      expect_gnt(1'b1, 2'd2, HI, "R9 high after clear");
      expect_gnt(1'b1, 2'd0, LO, "R9 low again");
      idle_cycle();

      // R8: empty lower level clears the high count
      cfg = 8'h70;
      vld = 3'b110; typ = {WRI, CRD, OTH};
      expect_gnt(1'b1, 2'd2, HI, "R8 pass 1");
      vld = 3'b100;
      expect_gnt(1'b1, 2'd2, HI, "R8 lower empty");
      vld = 3'b110;
      expect_gnt(1'b1, 2'd2, HI, "R8 count restarted");
      expect_gnt(1'b1, 2'd1, MD, "R8 yield after restart");
      idle_cycle();

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule